// File: doc/BRIEF.md
# Keyed Watchdog Timer

A watchdog peripheral that sits on a simple single-cycle register bus. Software loads a reload value, sets a run bit, and from then on must service the block by writing one fixed key to the restart register before the down-counter runs out. The counter steps on every clock, or only on an external 1 MHz tick enable, as a control bit selects. When it reaches zero it stops there and emits a one-cycle expiry strobe. From that strobe the block derives a gated reset request, a gated interrupt and an optional stretched external reset pulse. A reset-scope code is presented continuously so that the reset distribution outside the block knows what to reset.

A sticky flag records that an expiry took place while the secondary-image boot request was set. Software reads it and clears it, together with the boot request, through a clear register. The bus has no handshake. A write takes effect at the clock edge where `wr_en_i` is high, and read data is a combinational function of `addr_i`.

Top module: `wdog_timer`

## Requirements
- R1: After reset every register reads 0 and all outputs are low. Offset 0x04 (reload) and offset 0x0C (control, bits 7:0) read back what was written. Offset 0x00 reads the current count.
- R2: A control write that sets bit 0 (run) while run is clear loads the count from the reload register. A control write that clears run halts the count with its value kept. While halted, ticks do not change the count.
- R3: While running, the count drops by one per step. A step is every clock when control bit 4 is 0, and only a clock with `tick_i` high when bit 4 is 1. After exactly reload steps the count is 0 and stays there. `expire_o` is high for only the first cycle in which the count reads 0. A reload of 0 never expires.
- R4: Writing exactly 0x00004755 to offset 0x08 loads the count from the reload register. Any other value written there leaves the count unchanged.
- R5: `rst_req_o` pulses together with `expire_o` only when control bit 1 is set.
- R6: `irq_o` pulses together with `expire_o` only when control bit 2 is set.
- R7: When control bit 3 is set, `ext_rst_o` goes high in the expiry cycle and stays high for exactly PULSE_CYCLES cycles. Otherwise it stays low.
- R8: `scope_o` equals control bits 6:5. Code 0 selects SoC reset, 1 selects full-chip reset and 2 selects CPU-only reset.
- R9: An expiry while control bit 7 is set sets bit 1 of offset 0x10. The bit stays set until it is cleared. An expiry with bit 7 clear leaves it at 0.
- R10: Writing a value with bit 0 = 1 to offset 0x14 clears the 0x10 status bit and control bit 7. A value with bit 0 = 0 has no effect.
- R11: A restart key that lands on the edge of the final step wins, so the count reloads and no expiry occurs. A status clear that lands on the expiry cycle loses, so the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 1 MHz step enable used when control bit 4 is 1 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| rst_req_o | output | 1 | Reset request pulse |
| irq_o | output | 1 | Interrupt pulse |
| ext_rst_o | output | 1 | Stretched external reset |
| scope_o | output | 2 | Reset scope code |
| expire_o | output | 1 | One-cycle expiry strobe |

## Verification
Two pairs of events can meet on one edge. The first is a restart and the final decrement. The bench counts clocks after an enable with reload 3 and places the key write on the third edge, then expects the count to read 3 with no strobe. The second is an expiry and a status clear. The clear write is issued in the very cycle that `expire_o` is high, and the bench expects the flag set and the boot-request bit clear afterwards.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] A_COUNT  = 5'h00;
  localparam logic [ADDR_W-1:0] A_RELOAD = 5'h04;
  localparam logic [ADDR_W-1:0] A_KICK   = 5'h08;
  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h0C;
  localparam logic [ADDR_W-1:0] A_BSTAT  = 5'h10;
  localparam logic [ADDR_W-1:0] A_BCLR   = 5'h14;
  localparam logic [31:0] KICK_KEY = 32'h0000_4755;

  typedef struct packed {
    logic       alt_boot;  // bit 7
    logic [1:0] scope;     // bits 6:5
    logic       tick_src;  // bit 4
    logic       ext_en;    // bit 3
    logic       irq_en;    // bit 2
    logic       rst_en;    // bit 1
    logic       run;       // bit 0
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              expire,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              load_req,
  output logic              boot_sts,
  output logic [DATA_W-1:0] rdata
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic  wr_ctrl, wr_kick, wr_clr;
  ctrl_t ctrl_new;

  assign ctrl_new = ctrl_t'(wdata[CTRL_W-1:0]);
  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign wr_kick  = wr_en && (addr == A_KICK) && (wdata == DATA_W'(KICK_KEY));
  assign wr_clr   = wr_en && (addr == A_BCLR) && wdata[0];
  assign load_req = wr_kick || (wr_ctrl && ctrl_new.run && !ctrl.run);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      reload   <= '0;
      boot_sts <= 1'b0;
    end else begin
      if (wr_en && addr == A_RELOAD) reload <= wdata[CNT_W-1:0];
      if (wr_ctrl) ctrl <= ctrl_new;
      else if (wr_clr) ctrl.alt_boot <= 1'b0;
      // a fresh expiry outranks a clear on the same edge
      if (expire && ctrl.alt_boot) boot_sts <= 1'b1;
      else if (wr_clr) boot_sts <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_COUNT:  rdata = DATA_W'(cnt);
      A_RELOAD: rdata = DATA_W'(reload);
      A_CTRL:   rdata = DATA_W'(ctrl);
      A_BSTAT:  rdata = DATA_W'({boot_sts, 1'b0});
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else if (load) begin
      cnt    <= reload;
      expire <= 1'b0;
    end else if (run && step && cnt != '0) begin
      cnt    <= cnt - ONE;
      expire <= (cnt == ONE);
    end else begin
      expire <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int RW = $clog2(LEN + 1);
  logic [RW-1:0] rem;

  always_ff @(posedge clk) begin
    if (!rst_n) rem <= '0;
    else if (trig) rem <= RW'(LEN - 1);
    else if (rem != '0) rem <= rem - RW'(1);
  end

  assign active = trig || (rem != '0);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int CNT_W        = 32,
  parameter int PULSE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_req_o,
  output logic              irq_o,
  output logic              ext_rst_o,
  output logic [1:0]        scope_o,
  output logic              expire_o
);
  ctrl_t            ctrl_w;
  logic [CNT_W-1:0] reload_w, cnt_w;
  logic             load_w, boot_w, expire_w, step_w;

  wdog_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i),
    .wdata(wdata_i), .cnt(cnt_w), .expire(expire_w), .ctrl(ctrl_w),
    .reload(reload_w), .load_req(load_w), .boot_sts(boot_w),
    .rdata(rdata_o)
  );

  assign step_w = ctrl_w.tick_src ? tick_i : 1'b1;

  wdog_count #(.CNT_W(CNT_W)) count_i (
    .clk(clk), .rst_n(rst_n), .run(ctrl_w.run), .step(step_w),
    .load(load_w), .reload(reload_w), .cnt(cnt_w), .expire(expire_w)
  );

  wdog_stretch #(.LEN(PULSE_CYCLES)) stretch_i (
    .clk(clk), .rst_n(rst_n), .trig(expire_w && ctrl_w.ext_en),
    .active(ext_rst_o)
  );

  assign expire_o  = expire_w;
  assign rst_req_o = expire_w && ctrl_w.rst_en;
  assign irq_o     = expire_w && ctrl_w.irq_en;
  assign scope_o   = ctrl_w.scope;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [4:0]       addr,
  input logic             clr_bit,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic             expire,
  input logic             rst_req,
  input logic             irq,
  input logic             boot
);
  p_expire_from_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> ($past(cnt) == CNT_W'(1)));
  p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
  p_halt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_en) |=> $stable(cnt));
  p_reset_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == '0));
  p_irq_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == '0));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (boot && !(wr_en && addr == 5'h14 && clr_bit)) |=> boot);
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i),
  .clr_bit(wdata_i[0]), .run(ctrl_w.run), .cnt(cnt_w),
  .expire(expire_w), .rst_req(rst_req_o), .irq(irq_o), .boot(boot_w)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req, irq, ext_rst, expire;
  logic [1:0]  scope;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.PULSE_CYCLES(PULSE)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rst_req_o(rst_req),
    .irq_o(irq), .ext_rst_o(ext_rst), .scope_o(scope), .expire_o(expire)
  );

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic tick_once();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) step();
    // R1 reset state
    rd(5'h00, v); check("R1 count", v, 0);
    rd(5'h04, v); check("R1 reload", v, 0);
    rd(5'h0C, v); check("R1 ctrl", v, 0);
    rd(5'h10, v); check("R1 status", v, 0);
    check("R1 outputs", {rst_req, irq, ext_rst, expire, scope}, 0);
    rst_n = 1'b1;
    step();
    wr(5'h04, 32'h1234_5678); rd(5'h04, v); check("R1 reload rb", v, 32'h1234_5678);
    wr(5'h0C, 32'h60); rd(5'h0C, v); check("R1 ctrl rb", v, 32'h60);
    // R8 scope codes
    for (int s = 0; s < 4; s++) begin
      wr(5'h0C, s << 5); check("R8 scope", scope, s);
    end
    // tick mode, frozen counter
    wr(5'h0C, 0); wr(5'h04, 100);
    wr(5'h0C, 32'h11); rd(5'h00, v); check("R2 load on enable", v, 100);
    repeat (5) step();
    rd(5'h00, v); check("R3 no tick no step", v, 100);
    tick_once(); rd(5'h00, v); check("R3 tick step", v, 99);
    wr(5'h04, 77);
    wr(5'h08, 32'h4756); rd(5'h00, v); check("R4 bad key", v, 99);
    wr(5'h08, 32'h0001_4755); rd(5'h00, v); check("R4 bad upper", v, 99);
    wr(5'h08, 32'h4755); rd(5'h00, v); check("R4 key loads", v, 77);
    tick_once(); rd(5'h00, v); check("R3 tick step2", v, 76);
    wr(5'h0C, 32'h10); tick_once(); rd(5'h00, v); check("R2 halt keeps", v, 76);
    wr(5'h0C, 32'h11); rd(5'h00, v); check("R2 re-enable loads", v, 77);
    // sweep: reload 1..8, output enables 0..7, clock-step mode
    for (int r = 1; r <= 8; r++) begin
      for (int c = 0; c < 8; c++) begin
        int hi;
        wr(5'h0C, 0); wr(5'h04, r);
        wr(5'h0C, (c << 1) | 1);
        addr = 5'h00;
        for (int k = 1; k < r; k++) begin
          step(); check("R3 early", expire, 0);
        end
        step();
        check("R3 expire", expire, 1);
        rd(5'h00, v); check("R3 zero", v, 0);
        check("R5 rst_req", rst_req, c[0]);
        check("R6 irq", irq, c[1]);
        hi = ext_rst ? 1 : 0;
        step(); check("R3 single strobe", expire, 0);
        if (ext_rst) hi++;
        for (int j = 0; j < PULSE + 2; j++) begin
          step(); if (ext_rst) hi++;
        end
        check("R7 pulse length", hi, c[2] ? PULSE : 0);
        rd(5'h00, v); check("R3 stays zero", v, 0);
      end
    end
    // R3 reload of zero
    wr(5'h0C, 0); wr(5'h04, 0); wr(5'h0C, 32'h03);
    v = 0;
    for (int j = 0; j < 4; j++) begin step(); v = v | 32'(expire); end
    check("R3 zero reload", v, 0);
    // R11 restart on final edge
    wr(5'h0C, 0); wr(5'h04, 3); wr(5'h0C, 32'h03);
    step(); step();
    wr(5'h08, 32'h4755);
    check("R11 restart wins", expire, 0);
    rd(5'h00, v); check("R11 count reloaded", v, 3);
    step(); step(); step(); check("R11 later expiry", expire, 1);
    // R9/R10 sticky flag
    wr(5'h0C, 0); wr(5'h04, 2); wr(5'h0C, 32'h81);
    step(); step(); check("R9 expire", expire, 1);
    step(); rd(5'h10, v); check("R9 set", v, 2);
    wr(5'h14, 0); rd(5'h10, v); check("R10 no clear", v, 2);
    repeat (4) step();
    rd(5'h10, v); check("R9 sticky", v, 2);
    wr(5'h14, 1); rd(5'h10, v); check("R10 cleared", v, 0);
    rd(5'h0C, v); check("R10 boot bit cleared", v, 32'h01);
    wr(5'h0C, 0); wr(5'h04, 2); wr(5'h0C, 32'h01);
    repeat (4) step();
    rd(5'h10, v); check("R9 no alt boot", v, 0);
    // R11 clear on expiry cycle
    wr(5'h0C, 0); wr(5'h04, 2); wr(5'h0C, 32'h81);
    step(); step(); check("R11 expire", expire, 1);
    wr(5'h14, 1); rd(5'h10, v); check("R11 set wins", v, 2);
    rd(5'h0C, v); check("R11 boot bit cleared", v, 32'h01);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule